// File: doc/BRIEF.md
# Cascadable Column Driver Data Capture and Chip Select

This block is the data-capture front end of one column driver in a chain of identical drivers that share one serial data line, one shift clock and one latch pulse. Each chip takes one data bit on every falling edge of the shift clock while it is selected, and fills a 96-bit line register. A latch pulse copies the line register into a 96-bit output latch. Every output bit then drives a 2-bit level code that picks one of four drive levels.

Selection passes down the chain through a pair of enable pins. One pin is this chip's enable input and the other is its enable output. The direction bit decides which pin plays which role, and it also reverses the order in which the line register is filled. A chip with its enable input held low starts capturing right after a latch pulse. Once it has taken 96 bits it drops its enable output for one shift-clock cycle, which selects the next chip, and it ignores data from then until the next latch pulse.

Top module: `seg_chain_select`

## Requirements
- R1: While `rstN` is low the output latch is all zero, so `segLevel` is `{polarity, polarity}` for every column. Both enable outputs read high. The chip is deselected and its bit count is zero.
- R2: With `dirSel` = 0, pin 1 is the enable output (`en1Oe` = 1) and pin 2 is the enable input (`en2Oe` = 0). With `dirSel` = 1 the roles are reversed. The pin that is not driven reads high on its output port.
- R3: After a latch pulse, a deselected chip captures nothing on a falling edge where its enable input is high. It captures the current `dataIn` bit on the first falling edge where its enable input is low, and that edge selects it.
- R4: The k-th captured bit since the last latch pulse (k = 0..95) is written to line position k when `dirSel` = 0, and to line position 95-k when `dirSel` = 1.
- R5: The falling edge that captures the 96th bit pulls the enable output low. The next falling edge returns it high, so the low phase lasts exactly one shift-clock period, measured from falling edge to falling edge.
- R6: After 96 captures the chip is deselected. Further data bits change neither its line register nor its enable output until the next latch pulse.
- R7: `latchPulse` is sampled on a falling edge of the shift clock. When it is seen high, the output latch loads the line register and the bit count and the selection are cleared; no data is captured on that edge. While `latchPulse` is high the enable output is high. The output latch changes on no other edge.
- R8: Column i drives `segLevel[2i+1:2i]` = {`polarity`, latch bit i XOR `polarity`}. Bit 0 is on/off and bit 1 selects the level pair. The four codes are 00 (off, phase 0), 01 (on, phase 0), 10 (on, phase 1) and 11 (off, phase 1).
- R9: Once selected, a chip keeps capturing until it holds 96 bits, even if its enable input goes high again.
- R10: When two chips are chained, with the first chip's enable output driving the second chip's enable input, the second chip captures stream bits 96 to 191, starting on the falling edge that ends the first chip's low enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock; data and control act on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dirSel | input | 1 | Direction bit: swaps the roles of the enable pins and reverses the fill order |
| latchPulse | input | 1 | Line latch request, sampled on a falling edge |
| dataIn | input | 1 | Serial display data bit |
| polarity | input | 1 | Frame polarity used to form the level codes |
| en1In | input | 1 | Enable pin 1, input side (used when dirSel = 1) |
| en2In | input | 1 | Enable pin 2, input side (used when dirSel = 0) |
| en1Out | output | 1 | Enable pin 1, output value |
| en1Oe | output | 1 | Enable pin 1, output enable |
| en2Out | output | 1 | Enable pin 2, output value |
| en2Oe | output | 1 | Enable pin 2, output enable |
| segLevel | output | 192 | Two-bit level code per column, column i at bits 2i+1:2i |

## Verification
The bench chains two chips and runs a random 192-bit stream through them in both directions. A fill index that is not mirrored, or a handover that comes one edge early or late, shows up as the second chip latching a shifted or overlapping slice of the stream. It counts the low samples of each enable output and checks their exact cycle, so a pulse that lasts two cycles, or that repeats while extra bits arrive after the chips are full, is reported. Directed cases follow. An enable input held high must leave the line empty. An enable input released after one bit must not stop the capture. A latch pulse that arrives while the second chip's pulse is still low must force that enable output high.

// File: rtl/segsel_pkg.sv
package segsel_pkg;
  // Number of columns handled by one chip.
  localparam int LINE_W = 96;
  // Width of the capture counter and of a line index.
  localparam int IDX_W  = $clog2(LINE_W);
  // Width of one level code.
  localparam int CODE_W = 2;

  // Strobes from the control to the datapath for one falling edge.
  typedef struct packed {
    logic             capture;  // write dataIn at idx
    logic             load;     // copy the line register into the output latch
    logic [IDX_W-1:0] idx;      // line position for this capture
  } strobe_t;
endpackage

// File: rtl/segsel_ctrl.sv
module segsel_ctrl
  import segsel_pkg::*;
(
  input  logic    shiftClk,
  input  logic    rstN,
  input  logic    latchPulse,
  input  logic    dirSel,
  input  logic    enIn,
  output strobe_t strobe,
  output logic    endFlag
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(LINE_W - 1);

  logic [IDX_W-1:0] bitCnt;
  logic             selected;
  logic             full;
  logic             lastBit;

  // A capture happens when no latch is pending, the line is not full, and the
  // chip is already selected or sees its enable input low (active low).
  always_comb begin
    strobe.load    = latchPulse;
    strobe.capture = !latchPulse && !full && (selected || !enIn);
    strobe.idx     = dirSel ? (LastIdx - bitCnt) : bitCnt;
  end

  assign lastBit = (bitCnt == LastIdx);

  always_ff @(negedge shiftClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      selected <= 1'b0;
      full     <= 1'b0;
      endFlag  <= 1'b0;
    end else if (latchPulse) begin
      bitCnt   <= '0;
      selected <= 1'b0;
      full     <= 1'b0;
      endFlag  <= 1'b0;
    end else if (strobe.capture) begin
      if (lastBit) begin
        bitCnt   <= '0;
        selected <= 1'b0;
        full     <= 1'b1;
        endFlag  <= 1'b1;
      end else begin
        bitCnt   <= bitCnt + 1'b1;
        selected <= 1'b1;
        endFlag  <= 1'b0;
      end
    end else begin
      endFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/segsel_datapath.sv
module segsel_datapath
  import segsel_pkg::*;
(
  input  logic                       shiftClk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic                       dataIn,
  input  logic                       polarity,
  output logic [CODE_W*LINE_W-1:0]   segLevel
);
  logic [LINE_W-1:0] lineReg;
  logic [LINE_W-1:0] outLatch;

  always_ff @(negedge shiftClk or negedge rstN) begin
    if (!rstN) begin
      lineReg  <= '0;
      outLatch <= '0;
    end else begin
      if (strobe.load) outLatch <= lineReg;
      if (strobe.capture) lineReg[strobe.idx] <= dataIn;
    end
  end

  // Per column: bit 1 = level pair (polarity), bit 0 = on/off.
  for (genvar col = 0; col < LINE_W; col++) begin : g_col
    assign segLevel[CODE_W*col +: CODE_W] = {polarity, outLatch[col] ^ polarity};
  end
endmodule

// File: rtl/seg_chain_select.sv
module seg_chain_select
  import segsel_pkg::*;
(
  input  logic                      shiftClk,
  input  logic                      rstN,
  input  logic                      dirSel,
  input  logic                      latchPulse,
  input  logic                      dataIn,
  input  logic                      polarity,
  input  logic                      en1In,
  input  logic                      en2In,
  output logic                      en1Out,
  output logic                      en1Oe,
  output logic                      en2Out,
  output logic                      en2Oe,
  output logic [CODE_W*LINE_W-1:0]  segLevel
);
  strobe_t strobe;
  logic    endFlag;
  logic    enIn;
  logic    enOut;

  assign enIn   = dirSel ? en1In : en2In;
  assign enOut  = !(endFlag && !latchPulse);

  assign en1Oe  = !dirSel;
  assign en2Oe  = dirSel;
  assign en1Out = dirSel ? 1'b1 : enOut;
  assign en2Out = dirSel ? enOut : 1'b1;

  segsel_ctrl u_ctrl (
    .shiftClk   (shiftClk),
    .rstN       (rstN),
    .latchPulse (latchPulse),
    .dirSel     (dirSel),
    .enIn       (enIn),
    .strobe     (strobe),
    .endFlag    (endFlag)
  );

  segsel_datapath u_data (
    .shiftClk (shiftClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .polarity (polarity),
    .segLevel (segLevel)
  );
endmodule

// File: rtl/seg_chain_select_checker.sv
module seg_chain_select_checker
  import segsel_pkg::*;
(
  input logic                     shiftClk,
  input logic                     rstN,
  input logic                     dirSel,
  input logic                     latchPulse,
  input logic                     polarity,
  input logic                     en1Out,
  input logic                     en2Out,
  input logic                     en1Oe,
  input logic                     en2Oe,
  input logic [CODE_W*LINE_W-1:0] segLevel
);
  logic enOutSel;
  assign enOutSel = dirSel ? en2Out : en1Out;

  // R2: exactly one pin drives, chosen by the direction bit
  p_pin_roles_r2: assert property (@(negedge shiftClk) disable iff (!rstN)
    (en1Oe != en2Oe) && (en1Oe == !dirSel));

  // R5: a low enable output lasts one period only
  p_single_low_r5: assert property (@(negedge shiftClk) disable iff (!rstN)
    (!enOutSel && !latchPulse) |=> enOutSel);

  // R7: latch pulse forces both enable outputs high
  p_latch_high_r7: assert property (@(negedge shiftClk) disable iff (!rstN)
    latchPulse |-> (en1Out && en2Out));

  // R7: the output latch only moves on a latch edge
  p_latch_hold_r7: assert property (@(negedge shiftClk) disable iff (!rstN)
    !latchPulse |=> (!$stable(polarity) || $stable(segLevel)));
endmodule

bind seg_chain_select seg_chain_select_checker u_chk (.*);

// File: tb/seg_chain_select_bench.sv
module seg_chain_select_bench;
  localparam int W = 96;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, dirSel, latchPulse, dataIn, polarity, aEnCtl;
  logic aEn1Out, aEn1Oe, aEn2Out, aEn2Oe, bEn1Out, bEn1Oe, bEn2Out, bEn2Oe;
  logic aEn1In, aEn2In, bEn1In, bEn2In, aEnOut, bEnOut;
  logic [2*W-1:0] aLevel, bLevel;

  int checks = 0;
  int errors = 0;
  logic [2*W-1:0] stream;

  assign aEn1In = dirSel ? aEnCtl : 1'b1;
  assign aEn2In = dirSel ? 1'b1 : aEnCtl;
  assign bEn1In = dirSel ? aEn2Out : 1'b1;
  assign bEn2In = dirSel ? 1'b1 : aEn1Out;
  assign aEnOut = dirSel ? aEn2Out : aEn1Out;
  assign bEnOut = dirSel ? bEn2Out : bEn1Out;

  seg_chain_select u_seg_chain_select (
    .shiftClk(clk), .rstN(rstN), .dirSel(dirSel), .latchPulse(latchPulse),
    .dataIn(dataIn), .polarity(polarity), .en1In(aEn1In), .en2In(aEn2In),
    .en1Out(aEn1Out), .en1Oe(aEn1Oe), .en2Out(aEn2Out), .en2Oe(aEn2Oe),
    .segLevel(aLevel));

  seg_chain_select u_chipB (
    .shiftClk(clk), .rstN(rstN), .dirSel(dirSel), .latchPulse(latchPulse),
    .dataIn(dataIn), .polarity(polarity), .en1In(bEn1In), .en2In(bEn2In),
    .en1Out(bEn1Out), .en1Oe(bEn1Oe), .en2Out(bEn2Out), .en2Oe(bEn2Oe),
    .segLevel(bLevel));

  function automatic logic [W-1:0] placeBits(logic [W-1:0] ordered, logic dir);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[dir ? (W-1-k) : k] = ordered[k];
    return r;
  endfunction

  function automatic logic [2*W-1:0] levelOf(logic [W-1:0] lat, logic pol);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = {pol, lat[i] ^ pol};
    return r;
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change one ns after a rising edge; the design acts on falling edges.
  task automatic shiftBit(logic b);
    dataIn = b;
    @(negedge clk); @(posedge clk); #1;
  endtask

  task automatic doLatch();
    latchPulse = 1'b1;
    #1;
    check("R7 enable A high during latch", {191'd0, aEnOut}, {191'd0, 1'b1});
    check("R7 enable B high during latch", {191'd0, bEnOut}, {191'd0, 1'b1});
    @(negedge clk); @(posedge clk); #1;
    latchPulse = 1'b0;
  endtask

  task automatic runFrame(logic dir, int extra);
    int aLows = 0;
    int bLows = 0;
    dirSel = dir;
    aEnCtl = 1'b0;
    doLatch();
    for (int i = 0; i < 2*W; i++) begin
      logic b;
      b = 1'($urandom);
      stream[i] = b;
      shiftBit(b);
      if (!aEnOut) aLows++;
      if (!bEnOut) bLows++;
      if (i == W-1) check("R5 A low after 96th bit", {191'd0, aEnOut}, 192'd0);
      if (i == W)   check("R5 A high one cycle later", {191'd0, aEnOut}, {191'd0, 1'b1});
    end
    check("R5 B low on bit 191", {191'd0, bEnOut}, 192'd0);
    check("R5 A single low cycle", 192'(aLows), 192'd1);
    for (int j = 0; j < extra; j++) begin
      shiftBit(1'($urandom));
      if (!aEnOut) aLows++;
      if (!bEnOut) bLows++;
    end
    check("R6 no second pulse", 192'(aLows + bLows), 192'd2);
    doLatch();
    polarity = 1'($urandom);
    #1;
    check("R4 R10 chip A slice", aLevel, levelOf(placeBits(stream[W-1:0], dir), polarity));
    check("R4 R6 R10 chip B slice", bLevel, levelOf(placeBits(stream[2*W-1:W], dir), polarity));
    polarity = !polarity;
    #1;
    check("R8 polarity flip", aLevel, levelOf(placeBits(stream[W-1:0], dir), polarity));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ord;
    void'($urandom(32'h5EC0_0042));
    rstN = 1'b0; dirSel = 1'b0; latchPulse = 1'b0; dataIn = 1'b0;
    polarity = 1'b0; aEnCtl = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    check("R1 reset level A", aLevel, '0);
    check("R1 reset enables", {188'd0, aEn1Out, bEn1Out, aEn2Out, bEn2Out}, {188'd0, 4'hF});
    polarity = 1'b1; #1;
    check("R1 reset level with polarity", aLevel, {W{2'b11}});
    polarity = 1'b0;
    // R2: pin roles
    check("R2 dir0 roles", {190'd0, aEn1Oe, aEn2Oe}, {190'd0, 2'b10});
    dirSel = 1'b1; #1;
    check("R2 dir1 roles", {190'd0, aEn1Oe, aEn2Oe}, {190'd0, 2'b01});
    check("R2 undriven pin high", {191'd0, aEn1Out}, {191'd0, 1'b1});
    dirSel = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;

    // R3: enable input held high, nothing is captured
    aEnCtl = 1'b1;
    latchPulse = 1'b1; @(negedge clk); @(posedge clk); #1; latchPulse = 1'b0;
    for (int i = 0; i < 20; i++) shiftBit(1'b1);
    doLatch();
    check("R3 no capture while enable high", aLevel, '0);

    // R9: enable low for the first bit only
    aEnCtl = 1'b0;
    for (int i = 0; i < W; i++) begin
      ord[i] = 1'($urandom);
      shiftBit(ord[i]);
      aEnCtl = 1'b1;
    end
    check("R9 A stays selected until full", {191'd0, aEnOut}, 192'd0);
    doLatch();
    check("R9 A captured all 96 bits", aLevel, levelOf(ord, 1'b0));

    runFrame(1'b0, 0);
    runFrame(1'b1, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule